// File: doc/BRIEF.md
# Display window and orientation commander

This block sits between a drawing engine and a panel controller that takes a stream of bytes, each marked as an opcode or as a parameter. A single start strobe asks for the preamble that comes before any pixel burst. The block first sends the memory access orientation command with one parameter byte. That byte is built from a rotation code and a colour order bit. The block then sends the column window and the row window, each coordinate as a two-byte field, and ends with the opcode that opens a memory write. The pixel data that follows is not part of this block.

The request is checked before anything is sent. If the window is reversed, or does not fit the panel in the requested orientation, the block raises a one-cycle error and emits nothing. While a preamble is being sent the block ignores further start strobes. The cycle after the last byte is taken, a one-cycle done pulse marks completion. The panel has 176 columns and 220 rows. Rotations of 90 and 270 degrees swap those limits.

Top module: `disp_win_cmdr`

## Requirements
- R1: While reset is held, out_valid, done and err are all 0.
- R2: An accepted request produces exactly 13 tokens, in this order: opcode 36h, orientation parameter, opcode 2Ah, four column bytes, opcode 2Bh, four row bytes, opcode 2Ch. out_is_cmd is 1 on the four opcodes and 0 on all nine parameters. The first token is valid in the cycle after the start edge.
- R3: The orientation parameter has bit 7 = row mirror, bit 6 = column mirror, bit 5 = row/column exchange and bit 3 = BGR select. All other bits are 0. The rotation code (0 = 0, 1 = 90, 2 = 180, 3 = 270 degrees) sets the upper bits as follows: code 0 gives none, code 1 gives 80h|20h, code 2 gives 80h|40h, and code 3 gives 40h|20h.
- R4: The column parameters are sent as 00h, x_first, 00h, x_last.
- R5: The row parameters are sent as 00h, y_first, 00h, y_last. The opcode 2Ch with no parameter follows them as the last token.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_byte and out_is_cmd stay unchanged on the next cycle.
- R7: done is 1 for exactly one cycle. That cycle is the one after the edge at which the 2Ch token is accepted.
- R8: For rotation codes 0 and 2, x_last must be at most 175 and y_last at most 219. For codes 1 and 3, x_last must be at most 219 and y_last at most 175.
- R9: A start in idle with x_first > x_last, y_first > y_last, or an R8 violation makes err 1 for the next cycle only, and no token is sent. err and done are never 1 together.
- R10: A start strobe while tokens are pending is ignored. The running preamble keeps the values captured when it began, and no err is raised.
- R11: A start presented in the cycle where done is 1 is accepted. Its first token is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled at the rising edge |
| rot_code | input | 2 | Rotation: 0, 90, 180, 270 degrees as codes 0..3 |
| bgr_sel | input | 1 | Colour order select placed in bit 3 of the orientation byte |
| x_first | input | COORD_W | Window start column |
| x_last | input | COORD_W | Window end column |
| y_first | input | COORD_W | Window start row |
| y_last | input | COORD_W | Window end row |
| out_valid | output | 1 | Token on out_byte is valid |
| out_ready | input | 1 | Downstream accepts the token at the edge |
| out_byte | output | 8 | Token byte |
| out_is_cmd | output | 1 | 1 for an opcode, 0 for a parameter |
| done | output | 1 | One-cycle pulse after the final token is accepted |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
Completion and a new request can fall in the same cycle. One case is a start presented in the cycle where done is high. The other is a start held high across the edge where the 2Ch token is taken. The bench provokes both: it drives start at the negative edge on which it sees done, and it holds start through the end of a preamble. A behavioural queue model decides which start is accepted and which is ignored, and every output is compared with it on each clock. Random backpressure is layered on top, so the last handshake also lands next to stalls.

// File: rtl/disp_win_cmdr_pkg.sv
package disp_win_cmdr_pkg;

   localparam logic [7:0] OP_ORIENT = 8'h36;
   localparam logic [7:0] OP_COLWIN = 8'h2A;
   localparam logic [7:0] OP_ROWWIN = 8'h2B;
   localparam logic [7:0] OP_MEMWR  = 8'h2C;

   localparam int SEQ_LEN = 13;

   typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} seq_st_e;

   typedef struct packed {
      logic       is_cmd;
      logic [7:0] data;
   } tok_t;

   // rotation code: 0 -> 0 deg, 1 -> 90, 2 -> 180, 3 -> 270
   function automatic logic [7:0] orient_param(input logic [1:0] rot, input logic bgr);
      logic row_mir, col_mir, exch;
      row_mir = 1'b0;
      col_mir = 1'b0;
      exch    = 1'b0;
      case (rot)
         2'd1:    begin row_mir = 1'b1; exch = 1'b1; end
         2'd2:    begin row_mir = 1'b1; col_mir = 1'b1; end
         2'd3:    begin col_mir = 1'b1; exch = 1'b1; end
         default: ;
      endcase
      return {row_mir, col_mir, exch, 1'b0, bgr, 3'b000};
   endfunction

endpackage

// File: rtl/disp_win_cmdr_limit.sv
module disp_win_cmdr_limit #(
   parameter int COORD_W   = 8,
   parameter int PANEL_W   = 176,
   parameter int PANEL_H   = 220,
   parameter bit CHECK_FIT = 1'b1
) (
   input  logic [1:0]         rot,
   input  logic [COORD_W-1:0] x_first,
   input  logic [COORD_W-1:0] x_last,
   input  logic [COORD_W-1:0] y_first,
   input  logic [COORD_W-1:0] y_last,
   output logic               req_ok
);
   localparam logic [COORD_W-1:0] LIM_COL = COORD_W'(PANEL_W - 1);
   localparam logic [COORD_W-1:0] LIM_ROW = COORD_W'(PANEL_H - 1);

   logic order_ok;
   logic fit_ok;

   assign order_ok = (x_first <= x_last) && (y_first <= y_last);

   generate
      if (CHECK_FIT) begin : g_fit
         logic swapped;
         assign swapped = rot[0];
         assign fit_ok  = swapped ? ((x_last <= LIM_ROW) && (y_last <= LIM_COL))
                                  : ((x_last <= LIM_COL) && (y_last <= LIM_ROW));
      end else begin : g_nofit
         assign fit_ok = 1'b1;
      end
   endgenerate

   assign req_ok = order_ok && fit_ok;

endmodule

// File: rtl/disp_win_cmdr_fmt.sv
module disp_win_cmdr_fmt
   import disp_win_cmdr_pkg::*;
#(
   parameter int COORD_W = 8,
   parameter int IDX_W   = 4
) (
   input  logic [IDX_W-1:0]   idx,
   input  logic [7:0]         orient,
   input  logic [COORD_W-1:0] x_first,
   input  logic [COORD_W-1:0] x_last,
   input  logic [COORD_W-1:0] y_first,
   input  logic [COORD_W-1:0] y_last,
   output tok_t               tok
);
   logic [7:0] xf_hi, xl_hi, yf_hi, yl_hi;
   tok_t       slots [SEQ_LEN];

   generate
      if (COORD_W == 8) begin : g_narrow
         assign xf_hi = 8'h00;
         assign xl_hi = 8'h00;
         assign yf_hi = 8'h00;
         assign yl_hi = 8'h00;
      end else begin : g_wide
         assign xf_hi = 8'(x_first >> 8);
         assign xl_hi = 8'(x_last  >> 8);
         assign yf_hi = 8'(y_first >> 8);
         assign yl_hi = 8'(y_last  >> 8);
      end
   endgenerate

   always_comb begin
      slots[0]  = '{is_cmd: 1'b1, data: OP_ORIENT};
      slots[1]  = '{is_cmd: 1'b0, data: orient};
      slots[2]  = '{is_cmd: 1'b1, data: OP_COLWIN};
      slots[3]  = '{is_cmd: 1'b0, data: xf_hi};
      slots[4]  = '{is_cmd: 1'b0, data: x_first[7:0]};
      slots[5]  = '{is_cmd: 1'b0, data: xl_hi};
      slots[6]  = '{is_cmd: 1'b0, data: x_last[7:0]};
      slots[7]  = '{is_cmd: 1'b1, data: OP_ROWWIN};
      slots[8]  = '{is_cmd: 1'b0, data: yf_hi};
      slots[9]  = '{is_cmd: 1'b0, data: y_first[7:0]};
      slots[10] = '{is_cmd: 1'b0, data: yl_hi};
      slots[11] = '{is_cmd: 1'b0, data: y_last[7:0]};
      slots[12] = '{is_cmd: 1'b1, data: OP_MEMWR};
   end

   assign tok = (idx < IDX_W'(SEQ_LEN)) ? slots[idx] : '0;

endmodule

// File: rtl/disp_win_cmdr_seq.sv
module disp_win_cmdr_seq
   import disp_win_cmdr_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             req_ok,
   input  logic             out_ready,
   output logic             sending,
   output logic             capture,
   output logic [IDX_W-1:0] idx,
   output logic             done,
   output logic             err
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

   seq_st_e st;

   assign sending = (st == ST_SEND);
   assign capture = (st == ST_IDLE) && start && req_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         idx  <= '0;
         done <= 1'b0;
         err  <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  if (req_ok) begin
                     st  <= ST_SEND;
                     idx <= '0;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            ST_SEND: begin
               if (out_ready) begin
                  if (idx == LAST_IDX) begin
                     st   <= ST_IDLE;
                     idx  <= '0;
                     done <= 1'b1;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/disp_win_cmdr.sv
module disp_win_cmdr
   import disp_win_cmdr_pkg::*;
#(
   parameter int COORD_W   = 8,
   parameter int PANEL_W   = 176,
   parameter int PANEL_H   = 220,
   parameter bit CHECK_FIT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         rot_code,
   input  logic               bgr_sel,
   input  logic [COORD_W-1:0] x_first,
   input  logic [COORD_W-1:0] x_last,
   input  logic [COORD_W-1:0] y_first,
   input  logic [COORD_W-1:0] y_last,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [7:0]         out_byte,
   output logic               out_is_cmd,
   output logic               done,
   output logic               err
);
   localparam int IDX_W = $clog2(SEQ_LEN);

   generate
      if (COORD_W < 8 || COORD_W > 16) begin : g_bad_coord_w
         initial $fatal(1, "COORD_W must lie in 8..16");
      end
      if (PANEL_W < 1 || PANEL_H < 1 ||
          PANEL_W > (1 << COORD_W) || PANEL_H > (1 << COORD_W)) begin : g_bad_panel
         initial $fatal(1, "panel size does not fit COORD_W");
      end
   endgenerate

   logic               req_ok, sending, capture;
   logic [IDX_W-1:0]   idx;
   logic [1:0]         rot_q;
   logic               bgr_q;
   logic [COORD_W-1:0] xf_q, xl_q, yf_q, yl_q;
   tok_t               tok;

   disp_win_cmdr_limit #(
      .COORD_W(COORD_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .CHECK_FIT(CHECK_FIT)
   ) u_limit (
      .rot(rot_code), .x_first(x_first), .x_last(x_last),
      .y_first(y_first), .y_last(y_last), .req_ok(req_ok)
   );

   disp_win_cmdr_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .req_ok(req_ok),
      .out_ready(out_ready), .sending(sending), .capture(capture),
      .idx(idx), .done(done), .err(err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_q <= '0;
         bgr_q <= 1'b0;
         xf_q  <= '0;
         xl_q  <= '0;
         yf_q  <= '0;
         yl_q  <= '0;
      end else if (capture) begin
         rot_q <= rot_code;
         bgr_q <= bgr_sel;
         xf_q  <= x_first;
         xl_q  <= x_last;
         yf_q  <= y_first;
         yl_q  <= y_last;
      end
   end

   disp_win_cmdr_fmt #(.COORD_W(COORD_W), .IDX_W(IDX_W)) u_fmt (
      .idx(idx), .orient(orient_param(rot_q, bgr_q)),
      .x_first(xf_q), .x_last(xl_q), .y_first(yf_q), .y_last(yl_q),
      .tok(tok)
   );

   assign out_valid  = sending;
   assign out_byte   = tok.data;
   assign out_is_cmd = tok.is_cmd;

endmodule

// File: rtl/disp_win_cmdr_chk.sv
module disp_win_cmdr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_byte,
   input logic       out_is_cmd,
   input logic       done,
   input logic       err
);
   assert_first_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_is_cmd && out_byte == 8'h36));

   assert_orient_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_is_cmd && out_byte == 8'h36)
      |=> (out_valid && !out_is_cmd && (out_byte & 8'h17) == 8'h00));

   assert_memwr_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid && out_ready && out_is_cmd && out_byte == 8'h2C));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready)
      |=> (out_valid && $stable(out_byte) && $stable(out_is_cmd)));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!out_valid && !done));

   assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
endmodule

bind disp_win_cmdr disp_win_cmdr_chk u_chk (.*);

// File: tb/disp_win_cmdr_bench.sv
`timescale 1ns/1ps
module disp_win_cmdr_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] rot = 2'd0;
   logic       bgr = 1'b0;
   logic [7:0] xf = 8'd0, xl = 8'd0, yf = 8'd0, yl = 8'd0;
   logic       rdy = 1'b1;
   logic       out_valid, out_is_cmd, done, err;
   logic [7:0] out_byte;

   always #2 clk = ~clk;

   disp_win_cmdr u_disp_win_cmdr (
      .clk(clk), .rst_n(rst_n), .start(start), .rot_code(rot), .bgr_sel(bgr),
      .x_first(xf), .x_last(xl), .y_first(yf), .y_last(yl),
      .out_valid(out_valid), .out_ready(rdy), .out_byte(out_byte),
      .out_is_cmd(out_is_cmd), .done(done), .err(err)
   );

   int    errors = 0, checks = 0;
   bit    running = 0, rdy_rand = 0, prev_stall = 0, finished = 0;
   string phase = "R2";

   // behavioural reference
   logic [8:0] q[$];
   bit m_busy = 0, m_done = 0, m_err = 0;

   function automatic bit legal(input logic [1:0] r, input logic [7:0] a, b, c, d);
      int mx, my;
      mx = r[0] ? 219 : 175;
      my = r[0] ? 175 : 219;
      return (a <= b) && (c <= d) && (int'(b) <= mx) && (int'(d) <= my);
   endfunction

   function automatic logic [7:0] orient_exp(input logic [1:0] r, input logic g);
      logic [7:0] v;
      case (r)
         2'd1:    v = 8'hA0;
         2'd2:    v = 8'hC0;
         2'd3:    v = 8'h60;
         default: v = 8'h00;
      endcase
      return v | {4'b0, g, 3'b0};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_busy = 0; m_done = 0; m_err = 0;
      end else begin
         bit nd, ne;
         nd = 0; ne = 0;
         if (m_busy) begin
            if (rdy) begin
               void'(q.pop_front());
               if (q.size() == 0) begin m_busy = 0; nd = 1; end
            end
         end else if (start) begin
            if (legal(rot, xf, xl, yf, yl)) begin
               q.push_back({1'b1, 8'h36}); q.push_back({1'b0, orient_exp(rot, bgr)});
               q.push_back({1'b1, 8'h2A}); q.push_back(9'h000); q.push_back({1'b0, xf});
               q.push_back(9'h000);        q.push_back({1'b0, xl});
               q.push_back({1'b1, 8'h2B}); q.push_back(9'h000); q.push_back({1'b0, yf});
               q.push_back(9'h000);        q.push_back({1'b0, yl});
               q.push_back({1'b1, 8'h2C});
               m_busy = 1;
            end else ne = 1;
         end
         m_done = nd; m_err = ne;
      end
   end

   // compare every cycle, then choose ready for the next edge
   always @(negedge clk) begin
      if (rst_n && running) begin
         chk(out_valid == m_busy, {phase, " R2 valid"}, out_valid, m_busy);
         if (m_busy && q.size() > 0) begin
            int    pos;
            string t;
            pos = 13 - q.size();
            if (prev_stall)                  t = "R6 held token";
            else if (q[0][8])                t = "R2 opcode";
            else if (pos == 1)               t = "R3 orientation";
            else if (pos < 7)                t = "R4 column field";
            else                             t = "R5 row field";
            chk({out_is_cmd, out_byte} == q[0], {phase, " ", t},
                {out_is_cmd, out_byte}, q[0]);
         end
         chk(done == m_done, {phase, " R7 done"}, done, m_done);
         chk(err == m_err, {phase, " R9 err"}, err, m_err);
      end
      rdy = rdy_rand ? 1'($urandom_range(1, 0)) : 1'b1;
      prev_stall = out_valid && !rdy;
   end

   task automatic wait_idle();
      @(negedge clk);
      while (m_busy || out_valid) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic request(input logic [1:0] r, input logic g,
                          input logic [7:0] a, b, c, d);
      @(negedge clk);
      rot = r; bgr = g; xf = a; xl = b; yf = c; yl = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!out_valid && !done && !err, "R1 reset quiet", {out_valid, done, err}, 0);
      rst_n = 1'b1;
      running = 1;

      phase = "R3";
      for (int r = 0; r < 4; r++) request(2'(r), 1'(r & 1), 8'd3, 8'd40, 8'd7, 8'd90);
      request(2'd2, 1'b1, 8'd0, 8'd0, 8'd0, 8'd0);

      phase = "R6";
      rdy_rand = 1;
      for (int r = 0; r < 4; r++) request(2'(r), 1'(~r & 1), 8'(10 + r), 8'd120, 8'd5, 8'd150);
      rdy_rand = 0;

      phase = "R8";
      request(2'd0, 1'b0, 8'd0, 8'd175, 8'd0, 8'd219);
      request(2'd0, 1'b0, 8'd0, 8'd176, 8'd0, 8'd10);
      request(2'd2, 1'b0, 8'd0, 8'd10, 8'd0, 8'd220);
      request(2'd1, 1'b1, 8'd0, 8'd219, 8'd0, 8'd175);
      request(2'd3, 1'b0, 8'd0, 8'd10, 8'd0, 8'd176);
      request(2'd3, 1'b0, 8'd0, 8'd220, 8'd0, 8'd10);

      phase = "R9";
      request(2'd0, 1'b0, 8'd50, 8'd49, 8'd0, 8'd10);
      request(2'd1, 1'b0, 8'd0, 8'd10, 8'd30, 8'd29);
      request(2'd0, 1'b0, 8'd60, 8'd60, 8'd61, 8'd61);

      // start held while busy, then still high at the final handshake
      phase = "R10";
      begin
         bit seen_err;
         seen_err = 0;
         @(negedge clk);
         rot = 2'd1; bgr = 1'b0; xf = 8'd1; xl = 8'd2; yf = 8'd3; yl = 8'd4; start = 1'b1;
         @(negedge clk);
         xf = 8'd9; xl = 8'd8; rot = 2'd2; yf = 8'd100; yl = 8'd120;
         for (int i = 0; i < 13; i++) begin
            if (err) seen_err = 1;
            @(negedge clk);
         end
         start = 1'b0;
         chk(!seen_err, "R10 no err while busy", seen_err, 0);
         wait_idle();
      end

      phase = "R11";
      rdy_rand = 1;
      @(negedge clk);
      rot = 2'd3; bgr = 1'b1; xf = 8'd20; xl = 8'd200; yf = 8'd0; yl = 8'd175; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      rot = 2'd0; bgr = 1'b0; xf = 8'd5; xl = 8'd6; yf = 8'd7; yl = 8'd8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(out_valid && out_is_cmd && out_byte == 8'h36, "R11 start in done cycle",
          {out_valid, out_is_cmd, out_byte}, {2'b11, 8'h36});
      wait_idle();
      rdy_rand = 0;

      running = 0;
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule